// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one vector memory instruction into a stream of effective addresses, one per element. When the instruction is accepted, the block captures the scalar base, the signed immediate, the access width, the destination element width and the vector length. It then emits element 0 up to element VL-1, one per cycle, on a valid/ready output. It works out the addressing mode once, at acceptance. That decision uses three things: whether the address register is marked as a vector, a stride-select bit, and whether the immediate is zero.

Alongside each address the block reports three more fields. The first is the access size, which is always the operation width, because the data element width follows the operation width. The second is a truncation width for the register side. When the destination element width is narrower than the access, the loaded value is cut down to that width and packed, and no saturation is applied. The third is the mode. In indexed mode the block presents an element number on `idx_elem` and reads that element's index value from `idx_val` in the same cycle, as it would read from a register-file port.

Top module: `vec_ldst_agu`

## Requirements
- R1: After synchronous reset, `out_valid` and `busy` are 0.
- R2: If `ra_vec` is 1, the mode is indexed (`out_mode` = 2), whatever the stride bit and immediate are.
- R3: If `ra_vec` is 0 and `stride_sel` is 0, the mode is unit stride (`out_mode` = 0). If `ra_vec` is 0, `stride_sel` is 1 and the immediate is nonzero, the mode is element stride (`out_mode` = 1).
- R4: If `ra_vec` is 0, `stride_sel` is 1 and the immediate is zero, the mode falls back to unit stride (`out_mode` = 0).
- R5: In element-stride mode, element i goes to base + i × sign-extended immediate, modulo 2^ADDR_W.
- R6: In unit-stride mode, element i goes to base + sign-extended immediate + i × (1 << op_width), modulo 2^ADDR_W.
- R7: In indexed mode, element i goes to base + `idx_val`, modulo 2^ADDR_W, where `idx_val` is sampled while `idx_elem` equals i.
- R8: `out_size` equals the captured `op_width` code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). `out_trunc` is the smaller of the `dst_ew` code and `op_width`.
- R9: Each accepted instruction emits exactly min(vl, MAXVL) elements, numbered 0 upward on `out_elem`, with `out_last` set only on the final one. A length of 0 emits nothing.
- R10: While `out_valid` is 1 and `ready` is 0, every output field holds its value.
- R11: A `start` pulse that arrives while `busy` is 1 is ignored, and the running sequence continues with the operands it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new instruction when not busy |
| ra_vec | input | 1 | Address register is marked as a vector |
| stride_sel | input | 1 | Selects element stride when the immediate is nonzero |
| imm | input | IMM_W | Signed immediate offset or stride |
| base | input | ADDR_W | Scalar base address |
| op_width | input | 2 | Access width code |
| dst_ew | input | 2 | Destination element width code |
| vl | input | VL_W | Vector length |
| idx_elem | output | ELEM_W | Element whose index value is requested |
| idx_val | input | ADDR_W | Index value of element `idx_elem` |
| ready | input | 1 | Consumer accepts the current address |
| out_valid | output | 1 | Address output is valid |
| out_addr | output | ADDR_W | Effective address |
| out_mode | output | 2 | Addressing mode code |
| out_size | output | 2 | Access size code |
| out_trunc | output | 2 | Register-side truncation width code |
| out_elem | output | ELEM_W | Element number |
| out_last | output | 1 | Final element of the instruction |
| busy | output | 1 | Instruction in progress |

## Verification
The bench builds the block with ADDR_W = 32, IMM_W = 16 and MAXVL = 16. The narrow address lets bases near the top of the space, combined with negative immediates, show wraparound in all three modes. With a 16-element maximum, a full-length vector, the clamping of an over-long length, and a wrap of the element counter are all reached in a few dozen cycles. Random ready patterns cover stalls on the first element, on middle elements and on the last one.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT    = 2'd0,
    AM_ESTRIDE = 2'd1,
    AM_INDEXED = 2'd2
  } addr_mode_e;

  function automatic logic [1:0] trunc_code(input logic [1:0] op, input logic [1:0] dst);
    return (dst < op) ? dst : op;
  endfunction
endpackage

// File: rtl/vagu_mode_sel.sv
module vagu_mode_sel
  import vagu_pkg::*;
(
  input  logic       ra_vec,
  input  logic       stride_sel,
  input  logic       imm_nz,
  output addr_mode_e mode
);
  always_comb begin
    if (ra_vec)                  mode = AM_INDEXED;
    else if (stride_sel && imm_nz) mode = AM_ESTRIDE;
    else                         mode = AM_UNIT;
  end
endmodule

// File: rtl/vagu_seq.sv
module vagu_seq #(
  parameter  int MAXVL  = 64,
  localparam int ELEM_W = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VL_W   = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic              ready,
  output logic              accept,
  output logic              load,
  output logic [ELEM_W-1:0] cnt,
  output logic              out_valid,
  output logic [ELEM_W-1:0] out_elem,
  output logic              out_last,
  output logic              busy
);
  logic              active;
  logic [ELEM_W-1:0] last_idx;
  logic [VL_W-1:0]   vl_eff;
  logic              at_last;

  assign vl_eff  = (vl > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl;
  assign busy    = active | out_valid;
  assign accept  = start & ~busy;
  assign load    = active & (~out_valid | ready);
  assign at_last = (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      last_idx  <= '0;
      out_valid <= 1'b0;
      out_elem  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (accept) begin
        active   <= (vl_eff != '0);
        cnt      <= '0;
        last_idx <= ELEM_W'(vl_eff - VL_W'(1));
      end
      if (load) begin
        out_valid <= 1'b1;
        out_elem  <= cnt;
        out_last  <= at_last;
        cnt       <= cnt + ELEM_W'(1);
        if (at_last) active <= 1'b0;
      end else if (ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vagu_addr_calc.sv
module vagu_addr_calc
  import vagu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ELEM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  addr_mode_e        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] imm_ext,
  input  logic [1:0]        op_width,
  input  logic [1:0]        trunc,
  input  logic [ELEM_W-1:0] elem,
  input  logic [ADDR_W-1:0] idx_val,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_mode,
  output logic [1:0]        out_size,
  output logic [1:0]        out_trunc
);
  logic [ADDR_W-1:0] elem_ext;
  logic [ADDR_W-1:0] offset;

  assign elem_ext = ADDR_W'(elem);

  always_comb begin
    case (mode)
      AM_INDEXED: offset = idx_val;
      AM_ESTRIDE: offset = imm_ext * elem_ext;
      default:    offset = imm_ext + (elem_ext << op_width);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_mode  <= '0;
      out_size  <= '0;
      out_trunc <= '0;
    end else if (load) begin
      out_addr  <= base + offset;
      out_mode  <= mode;
      out_size  <= op_width;
      out_trunc <= trunc;
    end
  end
endmodule

// File: rtl/vec_ldst_agu.sv
module vec_ldst_agu
  import vagu_pkg::*;
#(
  parameter  int ADDR_W = 64,
  parameter  int IMM_W  = 16,
  parameter  int MAXVL  = 64,
  localparam int ELEM_W = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int VL_W   = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ra_vec,
  input  logic              stride_sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        op_width,
  input  logic [1:0]        dst_ew,
  input  logic [VL_W-1:0]   vl,
  output logic [ELEM_W-1:0] idx_elem,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_mode,
  output logic [1:0]        out_size,
  output logic [1:0]        out_trunc,
  output logic [ELEM_W-1:0] out_elem,
  output logic              out_last,
  output logic              busy
);
  addr_mode_e        mode_in, mode_l;
  logic [ADDR_W-1:0] base_l, imm_l;
  logic [1:0]        op_l, trunc_l;
  logic              accept, load;
  logic [ELEM_W-1:0] cnt;

  vagu_mode_sel u_mode (
    .ra_vec     (ra_vec),
    .stride_sel (stride_sel),
    .imm_nz     (imm != '0),
    .mode       (mode_in)
  );

  vagu_seq #(.MAXVL(MAXVL)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .vl        (vl),
    .ready     (ready),
    .accept    (accept),
    .load      (load),
    .cnt       (cnt),
    .out_valid (out_valid),
    .out_elem  (out_elem),
    .out_last  (out_last),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_l  <= AM_UNIT;
      base_l  <= '0;
      imm_l   <= '0;
      op_l    <= '0;
      trunc_l <= '0;
    end else if (accept) begin
      mode_l  <= mode_in;
      base_l  <= base;
      imm_l   <= ADDR_W'($signed(imm));
      op_l    <= op_width;
      trunc_l <= trunc_code(op_width, dst_ew);
    end
  end

  assign idx_elem = cnt;

  vagu_addr_calc #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_calc (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .mode      (mode_l),
    .base      (base_l),
    .imm_ext   (imm_l),
    .op_width  (op_l),
    .trunc     (trunc_l),
    .elem      (cnt),
    .idx_val   (idx_val),
    .out_addr  (out_addr),
    .out_mode  (out_mode),
    .out_size  (out_size),
    .out_trunc (out_trunc)
  );
endmodule

// File: rtl/vagu_checker.sv
module vagu_checker #(
  parameter int ADDR_W = 64,
  parameter int ELEM_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              out_valid,
  input logic              out_last,
  input logic [ELEM_W-1:0] out_elem,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_mode,
  input logic [1:0]        out_size,
  input logic [1:0]        out_trunc,
  input logic              busy
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && !busy)); // R1

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mode != 2'd3)); // R2

  AST_TRUNC_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_trunc <= out_size)); // R8

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ready && !out_last) |=>
      (out_valid && out_elem == ELEM_W'($past(out_elem) + 1'b1))); // R9

  AST_LAST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ready && out_last) |=> !out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_elem) &&
       $stable(out_last) && $stable(out_size) && $stable(out_trunc))); // R10

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R11
endmodule

bind vec_ldst_agu vagu_checker #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_elem  (out_elem),
  .out_addr  (out_addr),
  .out_mode  (out_mode),
  .out_size  (out_size),
  .out_trunc (out_trunc),
  .busy      (busy)
);

// File: tb/vec_ldst_agu_test.sv
`timescale 1ns/1ps
module vec_ldst_agu_test;
  localparam int AW = 32;
  localparam int IW = 16;
  localparam int MV = 16;
  localparam int EW = 4;
  localparam int VW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, ra_vec = 1'b0, stride_sel = 1'b0, ready = 1'b1;
  logic [IW-1:0] imm = '0;
  logic [AW-1:0] base = '0;
  logic [1:0]    op_width = '0, dst_ew = '0;
  logic [VW-1:0] vl = '0;
  logic [EW-1:0] idx_elem;
  logic [AW-1:0] idx_val;
  logic          out_valid, out_last, busy;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_mode, out_size, out_trunc;
  logic [EW-1:0] out_elem;
  logic [AW-1:0] idx_tab [MV];

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  assign idx_val = idx_tab[idx_elem];

  vec_ldst_agu #(.ADDR_W(AW), .IMM_W(IW), .MAXVL(MV)) uut (
    .clk(clk), .rst(rst), .start(start), .ra_vec(ra_vec), .stride_sel(stride_sel),
    .imm(imm), .base(base), .op_width(op_width), .dst_ew(dst_ew), .vl(vl),
    .idx_elem(idx_elem), .idx_val(idx_val), .ready(ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_mode(out_mode), .out_size(out_size),
    .out_trunc(out_trunc), .out_elem(out_elem), .out_last(out_last), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int mode_of(input bit rv, input bit sb, input logic [IW-1:0] im);
    if (rv) return 2;
    if (sb && im != 0) return 1;
    return 0;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int md, input logic [AW-1:0] bs,
      input logic [IW-1:0] im, input int op, input int i, input logic [AW-1:0] ix);
    logic [AW-1:0] sx;
    sx = {{(AW-IW){im[IW-1]}}, im};
    case (md)
      2:       return bs + ix;
      1:       return bs + sx * AW'(i);
      default: return bs + sx + (AW'(i) << op);
    endcase
  endfunction

  task automatic run(input bit rv, input bit sb, input logic [IW-1:0] im,
                     input logic [AW-1:0] bs, input logic [1:0] op, input logic [1:0] de,
                     input int n, input int rdy_pct, input bit restart);
    int md, exp_n, got, cyc;
    bit held;
    logic [AW-1:0] h_addr;
    logic [EW-1:0] h_elem;
    string mtag, atag;
    md    = mode_of(rv, sb, im);
    exp_n = (n > MV) ? MV : n;
    mtag  = rv ? "R2" : ((sb && im == 0) ? "R4" : "R3");
    atag  = (md == 2) ? "R7" : ((md == 1) ? "R5" : "R6");
    for (int k = 0; k < MV; k++) idx_tab[k] = $urandom;
    @(negedge clk);
    ra_vec = rv; stride_sel = sb; imm = im; base = bs; op_width = op; dst_ew = de;
    vl = VW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0; held = 0; h_addr = '0; h_elem = '0;
    while ((got < exp_n || busy) && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (restart && cyc == 3) begin
        start = 1'b1; base = ~bs; imm = im + 16'd3; vl = VW'(2);
      end else begin
        start = 1'b0;
      end
      if (held)
        chk(out_valid && out_addr == h_addr && out_elem == h_elem, "R10",
            {out_addr, 28'd0, out_elem}, {h_addr, 28'd0, h_elem});
      ready = ($urandom % 100) < rdy_pct;
      held = out_valid && !ready;
      h_addr = out_addr; h_elem = out_elem;
      if (out_valid && ready) begin
        chk(out_elem == EW'(got), "R9", out_elem, got);
        chk(out_last == (got == exp_n - 1), "R9", out_last, (got == exp_n - 1));
        chk(out_mode == md[1:0], mtag, out_mode, md);
        chk(out_addr == exp_addr(md, bs, im, op, got, idx_tab[got]), atag,
            out_addr, exp_addr(md, bs, im, op, got, idx_tab[got]));
        chk(out_size == op && out_trunc == ((de < op) ? de : op), "R8",
            {out_size, out_trunc}, {op, ((de < op) ? de : op)});
        got++;
      end
    end
    start = 1'b0;
    chk(got == exp_n, "R9", got, exp_n);
    if (restart) chk(got == exp_n && !busy, "R11", got, exp_n);
    @(negedge clk);
    ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < MV; k++) idx_tab[k] = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R1", {out_valid, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy, "R1", {out_valid, busy}, 0);

    // directed cases
    run(0, 0, 16'h0010, 32'h0000_1000, 2'd0, 2'd0, 5, 100, 0);   // unit, bytes
    run(0, 0, 16'h0000, 32'h0000_2000, 2'd1, 2'd1, 4, 100, 0);   // unit, halves
    run(0, 0, 16'hFFF8, 32'h0000_3000, 2'd2, 2'd3, 6, 70, 0);    // unit, words, neg imm
    run(0, 0, 16'h0008, 32'hFFFF_FFF0, 2'd3, 2'd1, 8, 60, 0);    // unit, dwords, wrap, truncate
    run(0, 1, 16'h0100, 32'h0001_0000, 2'd1, 2'd0, 7, 100, 0);   // element stride
    run(0, 1, 16'hFFF0, 32'h0000_0040, 2'd2, 2'd2, 9, 50, 0);    // element stride, neg, wrap
    run(0, 1, 16'h0000, 32'h0000_4000, 2'd2, 2'd1, 5, 100, 0);   // fallback to unit
    run(1, 1, 16'h0040, 32'h8000_0000, 2'd3, 2'd0, 6, 80, 0);    // indexed
    run(1, 0, 16'h0000, 32'hFFFF_FF00, 2'd0, 2'd3, 3, 100, 0);   // indexed, wrap
    run(0, 0, 16'h0004, 32'h0000_5000, 2'd2, 2'd2, 0, 100, 0);   // zero length
    run(0, 0, 16'h0000, 32'h0000_6000, 2'd0, 2'd0, 1, 20, 0);    // single element, stalls
    run(0, 1, 16'h0003, 32'h0000_7000, 2'd0, 2'd0, MV, 100, 0);  // full length
    run(0, 0, 16'h0002, 32'h0000_8000, 2'd1, 2'd0, 20, 60, 0);   // over-long length clamps
    run(0, 1, 16'h0020, 32'h0000_9000, 2'd3, 2'd2, 10, 40, 1);   // start while busy

    // random cases
    for (int t = 0; t < 40; t++) begin
      run(1'($urandom), 1'($urandom), IW'($urandom % 4 == 0 ? 0 : $urandom),
          $urandom, 2'($urandom), 2'($urandom), int'($urandom % 22),
          30 + int'($urandom % 71), 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule